// File: doc/BRIEF.md
# YCbCr 4:2:2 Bus Unpacker and Chroma Upsampler

This block receives YCbCr 4:2:2 video on a 24-pin parallel bus together with separate horizontal sync, vertical sync and data enable. The bus carries 16-, 20- or 24-bit words, and a static mode input selects the width. Every clock brings one luma sample and one chroma sample. Chroma alternates between Cb on even pixels and Cr on odd pixels, always on the same pins. The block unpacks each word into 12-bit components, left-justified. It then rebuilds the chroma component that each pixel lacks and emits one full YCbCr 4:4:4 pixel per clock.

A three-entry sample window supplies the previous, current and next samples. A small state machine tags each captured sample with its slot: blank, even or odd. Even pixels borrow Cr from the odd pixel that follows them. Odd pixels take the rounded mean of the surrounding Cb samples, or repeat the previous Cb when the pixel ends the line. Data enable and both syncs travel through the same registers as the pixels, so all outputs share one latency.

The slot state machine has three states. `SLOT_BLANK` is the state after reset and the state whenever data enable is low. `SLOT_EVEN` marks an even pixel slot and `SLOT_ODD` an odd one. Its transitions are:
- BLANK→EVEN when data enable rises.
- EVEN→ODD and ODD→EVEN while data enable stays high.
- EVEN→BLANK and ODD→BLANK when data enable falls.
- BLANK→BLANK while data enable is low.

Top module: `yc422_upsampler`

## Requirements
- R1: With mode code 0 or 3 (16-bit), luma is in[15:8] and chroma is in[23:16], each followed by four zero bits. in[7:0] has no effect on any output.
- R2: With mode code 1 (20-bit), luma is {in[15:8], in[3:2], 2'b00} and chroma is {in[23:16], in[7:6], 2'b00}.
- R3: With mode code 2 (24-bit), luma is {in[15:8], in[3:0]} and chroma is {in[23:16], in[7:4]}.
- R4: The first pixel after data enable rises is even. Pixels then alternate even, odd, even, and so on while data enable stays high.
- R5: An even pixel outputs its own chroma as Cb and the chroma of the next pixel (its odd partner) as Cr.
- R6: An odd pixel outputs its own chroma as Cr. Its Cb is (Cb_prev + Cb_next + 1) >> 1 when the following pixel belongs to the same line.
- R7: An odd pixel that ends its line (data enable low on the next clock) outputs the previous even pixel's Cb unchanged.
- R8: A pixel sampled at clock edge k appears on the outputs after edge k+2. Data enable and both syncs sampled at edge k appear after the same edge.
- R9: While out_de is low, out_y, out_cb and out_cr are zero.
- R10: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_mode | input | 2 | Bus width: 0 or 3 = 16-bit, 1 = 20-bit, 2 = 24-bit |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_data | input | 24 | Packed 4:2:2 bus word |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_y | output | 12 | Luma |
| out_cb | output | 12 | Blue-difference chroma |
| out_cr | output | 12 | Red-difference chroma |

## Verification
Two events can land on the same output cycle. One is an odd pixel that ends its line and must repeat Cb. The other is a sample that restarts pairing for the next line. The bench provokes this with one-clock blanking gaps, so the last odd pixel of one line sits one clock away from the first even pixel of the next. The reference model keeps the recorded inputs in arrays and rebuilds the expected pixel from data-enable history alone. A wrongly applied line end would show either an averaged Cb where a repeat belongs or a first pixel tagged odd.

// File: rtl/yc422_pkg.sv
package yc422_pkg;
    localparam int COMP_W = 12;
    localparam int BUS_W  = 24;

    typedef enum logic [1:0] {
        SLOT_BLANK = 2'd0,
        SLOT_EVEN  = 2'd1,
        SLOT_ODD   = 2'd2
    } slot_t;

    typedef struct packed {
        logic              de;
        logic              hs;
        logic              vs;
        logic [COMP_W-1:0] y;
        logic [COMP_W-1:0] c;
    } samp_t;
endpackage

// File: rtl/yc422_bus_unpack.sv
module yc422_bus_unpack
    import yc422_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [BUS_W-1:0]  data,
    output logic [COMP_W-1:0] luma,
    output logic [COMP_W-1:0] chroma
);
    always_comb begin
        unique case (mode)
            2'd1: begin
                luma   = {data[15:8], data[3:2], 2'b00};
                chroma = {data[23:16], data[7:6], 2'b00};
            end
            2'd2: begin
                luma   = {data[15:8], data[3:0]};
                chroma = {data[23:16], data[7:4]};
            end
            default: begin
                luma   = {data[15:8], 4'b0000};
                chroma = {data[23:16], 4'b0000};
            end
        endcase
    end
endmodule

// File: rtl/yc422_slot_fsm.sv
module yc422_slot_fsm
    import yc422_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  de_i,
    output slot_t slot_q
);
    slot_t slot_d;

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= SLOT_BLANK;
        else        slot_q <= slot_d;
    end

    always_comb begin
        unique case (slot_q)
            SLOT_BLANK: slot_d = de_i ? SLOT_EVEN : SLOT_BLANK;
            SLOT_EVEN:  slot_d = de_i ? SLOT_ODD  : SLOT_BLANK;
            SLOT_ODD:   slot_d = de_i ? SLOT_EVEN : SLOT_BLANK;
            default:    slot_d = SLOT_BLANK;
        endcase
    end

    AST_FIRST_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (de_i && slot_q == SLOT_BLANK) |=> (slot_q == SLOT_EVEN)); // R4
    AST_NO_DOUBLE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == SLOT_ODD) |=> (slot_q != SLOT_ODD)); // R4
endmodule

// File: rtl/yc422_chroma_avg.sv
module yc422_chroma_avg #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mean
);
    logic [W:0] sum;
    always_comb begin
        sum  = (W+1)'(a) + (W+1)'(b) + (W+1)'(1);
        mean = sum[W:1];
    end
endmodule

// File: rtl/yc422_upsampler.sv
module yc422_upsampler
    import yc422_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_mode,
    input  logic        in_de,
    input  logic        in_hs,
    input  logic        in_vs,
    input  logic [23:0] in_data,
    output logic        out_de,
    output logic        out_hs,
    output logic        out_vs,
    output logic [11:0] out_y,
    output logic [11:0] out_cb,
    output logic [11:0] out_cr
);
    logic [COMP_W-1:0] unp_y, unp_c;
    slot_t             slot_a;
    slot_t             slot_b;
    samp_t             stg_a, stg_b;
    logic [COMP_W-1:0] c_prev;
    logic [COMP_W-1:0] cb_mean;
    logic [COMP_W-1:0] nxt_y, nxt_cb, nxt_cr;

    yc422_bus_unpack u_unpack (
        .mode   (bus_mode),
        .data   (in_data),
        .luma   (unp_y),
        .chroma (unp_c)
    );

    yc422_slot_fsm u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .de_i   (in_de),
        .slot_q (slot_a)
    );

    yc422_chroma_avg #(.W(COMP_W)) u_avg (
        .a    (c_prev),
        .b    (stg_a.c),
        .mean (cb_mean)
    );

    // sample window: stg_a newest, stg_b centre, c_prev previous chroma
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_a  <= '0;
            stg_b  <= '0;
            slot_b <= SLOT_BLANK;
            c_prev <= '0;
        end else begin
            stg_a  <= '{de: in_de, hs: in_hs, vs: in_vs, y: unp_y, c: unp_c};
            stg_b  <= stg_a;
            slot_b <= slot_a;
            c_prev <= stg_b.c;
        end
    end

    always_comb begin
        nxt_y  = '0;
        nxt_cb = '0;
        nxt_cr = '0;
        unique case (slot_b)
            SLOT_EVEN: begin
                nxt_y  = stg_b.y;
                nxt_cb = stg_b.c;
                nxt_cr = stg_a.de ? stg_a.c : stg_b.c;
            end
            SLOT_ODD: begin
                nxt_y  = stg_b.y;
                nxt_cr = stg_b.c;
                nxt_cb = (stg_a.de && slot_a == SLOT_EVEN) ? cb_mean : c_prev;
            end
            default: begin
                nxt_y  = '0;
                nxt_cb = '0;
                nxt_cr = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_de <= 1'b0;
            out_hs <= 1'b0;
            out_vs <= 1'b0;
            out_y  <= '0;
            out_cb <= '0;
            out_cr <= '0;
        end else begin
            out_de <= stg_b.de;
            out_hs <= stg_b.hs;
            out_vs <= stg_b.vs;
            out_y  <= nxt_y;
            out_cb <= nxt_cb;
            out_cr <= nxt_cr;
        end
    end

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 3)  warm <= warm + 2'd1;
    end

    AST_DE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_de == $past(in_de, 3))); // R8
    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (out_hs == $past(in_hs, 3) && out_vs == $past(in_vs, 3))); // R8
    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && !out_de) |-> (out_y == '0 && out_cb == '0 && out_cr == '0)); // R9
endmodule

// File: tb/yc422_upsampler_tb.sv
`timescale 1ns/1ps
module yc422_upsampler_tb;
    localparam int MAXC = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'd0;
    logic        in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [23:0] in_data = '0;
    logic        out_de, out_hs, out_vs;
    logic [11:0] out_y, out_cb, out_cr;

    always #2.5 clk = ~clk;

    yc422_upsampler u_dut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_data(in_data),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    logic        s_de[MAXC], s_hs[MAXC], s_vs[MAXC], s_odd[MAXC];
    logic [1:0]  s_mode[MAXC];
    logic [23:0] s_data[MAXC];
    int          ncyc = 0;
    int          n_vec = 0, n_bad = 0;

    function automatic int ref_luma(input logic [1:0] m, input logic [23:0] d);
        if (m == 2'd1)      return (int'(d[15:8]) * 16) + (int'(d[3:2]) * 4);
        else if (m == 2'd2) return (int'(d[15:8]) * 16) + int'(d[3:0]);
        else                return int'(d[15:8]) * 16;
    endfunction

    function automatic int ref_chroma(input logic [1:0] m, input logic [23:0] d);
        if (m == 2'd1)      return (int'(d[23:16]) * 16) + (int'(d[7:6]) * 4);
        else if (m == 2'd2) return (int'(d[23:16]) * 16) + int'(d[7:4]);
        else                return int'(d[23:16]) * 16;
    endfunction

    task automatic cmp(input string tag, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
        end
    endtask

    function automatic string ytag(input logic [1:0] m);
        if (m == 2'd1) return "R2";
        if (m == 2'd2) return "R3";
        return "R1";
    endfunction

    task automatic check_cycle(input int n);
        int p;
        p = n - 2;
        if (p < 0) begin
            cmp("R10", "de", int'(out_de), 0);
            cmp("R10", "y",  int'(out_y), 0);
            return;
        end
        cmp("R8", "de", int'(out_de), int'(s_de[p]));
        cmp("R8", "hs", int'(out_hs), int'(s_hs[p]));
        cmp("R8", "vs", int'(out_vs), int'(s_vs[p]));
        if (!s_de[p]) begin
            cmp("R9", "y",  int'(out_y), 0);
            cmp("R9", "cb", int'(out_cb), 0);
            cmp("R9", "cr", int'(out_cr), 0);
        end else if (!s_odd[p]) begin
            cmp(ytag(s_mode[p]), "y", int'(out_y), ref_luma(s_mode[p], s_data[p]));
            cmp((p == 0 || !s_de[p-1]) ? "R4" : "R5", "cb", int'(out_cb),
                ref_chroma(s_mode[p], s_data[p]));
            cmp("R5", "cr", int'(out_cr), ref_chroma(s_mode[p+1], s_data[p+1]));
        end else begin
            int cprev, cnext;
            cprev = ref_chroma(s_mode[p-1], s_data[p-1]);
            cnext = ref_chroma(s_mode[p+1], s_data[p+1]);
            cmp(ytag(s_mode[p]), "y", int'(out_y), ref_luma(s_mode[p], s_data[p]));
            cmp("R6", "cr", int'(out_cr), ref_chroma(s_mode[p], s_data[p]));
            if (s_de[p+1]) cmp("R6", "cb", int'(out_cb), (cprev + cnext + 1) / 2);
            else           cmp("R7", "cb", int'(out_cb), cprev);
        end
    endtask

    task automatic drive(input int k);
        bus_mode = s_mode[k];
        in_de    = s_de[k];
        in_hs    = s_hs[k];
        in_vs    = s_vs[k];
        in_data  = s_data[k];
    endtask

    task automatic push(input logic de, input logic hs, input logic vs, input logic [1:0] m);
        s_de[ncyc]   = de;
        s_hs[ncyc]   = hs;
        s_vs[ncyc]   = vs;
        s_mode[ncyc] = m;
        s_data[ncyc] = 24'($urandom);
        // R4: pairing restarts at every rising data enable
        s_odd[ncyc]  = de && ncyc > 0 && s_de[ncyc-1] && !s_odd[ncyc-1];
        ncyc++;
    endtask

    initial begin
        for (int ln = 0; ln < 48; ln++) begin
            int gap, len;
            logic [1:0] m;
            m   = 2'(ln % 4);
            gap = 1 + (ln % 3);
            len = 2 * (1 + (ln * 7) % 9);
            for (int g = 0; g < gap; g++) push(1'b0, g == 0, (ln % 10) == 0, m);
            for (int i = 0; i < len; i++) push(1'b1, 1'b0, 1'b0, m);
        end
        for (int g = 0; g < 4; g++) push(1'b0, 1'b0, 1'b0, 2'd0);
        s_data[ncyc] = '0;
        s_de[ncyc]   = 1'b0;
        s_mode[ncyc] = 2'd0;

        // R10: outputs idle while reset is held, even with active input
        in_de = 1'b1; in_hs = 1'b1; in_vs = 1'b1; in_data = 24'hFFFFFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cmp("R10", "de", int'(out_de), 0);
        cmp("R10", "hs", int'(out_hs), 0);
        cmp("R10", "y",  int'(out_y), 0);
        cmp("R10", "cb", int'(out_cb), 0);
        cmp("R10", "cr", int'(out_cr), 0);
        rst_n = 1'b1;
        drive(0);
        for (int n = 0; n < ncyc + 2; n++) begin
            @(posedge clk);
            @(negedge clk);
            check_cycle(n);
            if (n + 1 < ncyc) drive(n + 1);
            else begin
                in_de = 1'b0; in_hs = 1'b0; in_vs = 1'b0; in_data = '0;
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule